// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the purely combinational control unit of a small single-issue datapath built around a subset of a classic 32-bit load/store instruction set. A main decoder reads only the 6-bit opcode. It produces the datapath steering bits: destination-register select, branch enable, memory read and write strobes, write-back source, ALU operand-B source and register-file write enable. It also produces a 2-bit ALU mode that tells the second stage how to choose the ALU operation.

The second stage, the ALU-control decoder, combines that mode with the opcode and the 6-bit function field. From them it forms a 4-bit ALU operation code and a shift-amount select. The shift-amount select routes instruction bits [10:6] into the ALU's B operand for shift instructions.

Because this second stage recognises the immediate arithmetic and logic opcodes itself, every register-register instruction shares one main-decoder pattern, and the immediate forms need no extra datapath paths. The decoder also flags any encoding it does not support. When it does, it blocks every architectural write and every memory access.

Top module: `ctl_decoder`

## Requirements
- R1: The ALU mode output `alu_mode` is encoded as follows. 2'b00 forces an add (0010). 2'b01 forces a subtract (0110). 2'b10 takes the operation from the function field. 2'b11 takes the operation from the immediate opcode.
- R2: A load (opcode 6'h23) gives `reg_dst`=0, `branch`=0, `mem_read`=1, `mem_to_reg`=1, `alu_mode`=00, `mem_write`=0, `alu_src`=1 and `reg_write`=1, whatever the function field holds.
- R3: A store (opcode 6'h2B) gives `mem_write`=1, `mem_read`=0, `reg_write`=0, `alu_src`=1 and `alu_mode`=00, with `reg_dst` and `mem_to_reg` both driven to 0.
- R4: A branch-on-equal (opcode 6'h04) gives `branch`=1, `alu_mode`=01, `alu_op`=0110, `alu_src`=0, `reg_write`=0 and `mem_write`=0.
- R5: Every supported register-register instruction (opcode 6'h00) gives the same main pattern: `reg_dst`=1, `reg_write`=1, `alu_src`=0, `alu_mode`=10, with branch and both memory strobes at 0.
- R6: Under mode 10 the function field selects `alu_op` as follows: 6'h24 gives AND 0000, 6'h25 gives OR 0001, 6'h20 gives add 0010, 6'h22 gives subtract 0110, 6'h2A gives set-less-than 0111, 6'h00 gives sll 1000, 6'h02 gives srl 1001 and 6'h03 gives sra 1010.
- R7: `shamt_sel` is 1 exactly for sll, srl and sra (function fields 6'h00, 6'h02 and 6'h03 under opcode 6'h00), and 0 for every other encoding.
- R8: The immediate forms all give `reg_write`=1, `reg_dst`=0, `alu_src`=1 and `alu_mode`=11. Their opcodes and `alu_op` values are addi 6'h08 → 0010, subi 6'h09 → 0110, andi 6'h0C → 0000 and ori 6'h0D → 0001.
- R9: `zero_ext` is 1 only for andi and ori. For every other encoding it is 0, which means the immediate is sign-extended.
- R10: An opcode outside the supported set gives `illegal`=1 with every other control output 0, `alu_mode`=00 and `alu_op`=0010.
- R11: Opcode 6'h00 with an unsupported function field gives `illegal`=1, `reg_write`=0, both memory strobes 0, `shamt_sel`=0 and `alu_op`=0010. The other outputs keep the register-register pattern.
- R12: `illegal` is 0 for every supported instruction. Instruction bits outside the opcode and function fields never affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word; opcode in [31:26], function in [5:0] |
| reg_dst | output | 1 | Write-register select: 1 = rd field, 0 = rt field |
| branch | output | 1 | Conditional branch enable |
| mem_read | output | 1 | Data memory read strobe |
| mem_to_reg | output | 1 | Write-back from memory (1) or ALU (0) |
| mem_write | output | 1 | Data memory write strobe |
| alu_src | output | 1 | ALU B from extended immediate (1) or register (0) |
| reg_write | output | 1 | Register file write enable |
| alu_mode | output | 2 | Mode passed from main decoder to ALU control |
| alu_op | output | 4 | ALU operation code |
| shamt_sel | output | 1 | Route instr[10:6] into ALU B for shifts |
| zero_ext | output | 1 | Zero-extend (1) or sign-extend (0) the immediate |
| illegal | output | 1 | Unsupported opcode or function field |

## Verification
The bench builds the decoder with its default 32-bit instruction width. That is the only width at which the fixed opcode and function positions are meaningful. At this width every supported opcode and function code can be reached, along with random bytes in the register, shift-amount and immediate fields.

Random words mix supported and unsupported opcode and function values. As a result, both illegal-encoding paths are exercised many times, and so is the ignoring of the fields that must not matter.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int AOP_W  = 4;
    localparam int MODE_W = 2;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_SUBI  = 6'h09;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;

    localparam logic [FN_W-1:0] FN_SLL = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA = 6'h03;
    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [MODE_W-1:0] {
        MODE_ADD   = 2'b00,
        MODE_SUB   = 2'b01,
        MODE_FUNCT = 2'b10,
        MODE_IMM   = 2'b11
    } alu_mode_e;

    typedef enum logic [AOP_W-1:0] {
        AOP_AND = 4'b0000,
        AOP_OR  = 4'b0001,
        AOP_ADD = 4'b0010,
        AOP_SUB = 4'b0110,
        AOP_SLT = 4'b0111,
        AOP_SLL = 4'b1000,
        AOP_SRL = 4'b1001,
        AOP_SRA = 4'b1010
    } alu_op_e;

    typedef struct packed {
        logic      reg_dst;
        logic      branch;
        logic      mem_read;
        logic      mem_to_reg;
        logic      mem_write;
        logic      alu_src;
        logic      reg_write;
        logic      zero_ext;
        alu_mode_e mode;
        logic      bad_opc;
    } main_ctl_t;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output main_ctl_t        ctl
);

    always_comb begin
        ctl = '0;
        ctl.mode = MODE_ADD;
        case (opcode)
            OPC_RTYPE: begin
                ctl.reg_dst   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.mode      = MODE_FUNCT;
            end
            OPC_LOAD: begin
                ctl.mem_read   = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.alu_src    = 1'b1;
                ctl.reg_write  = 1'b1;
            end
            OPC_STORE: begin
                ctl.mem_write = 1'b1;
                ctl.alu_src   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.branch = 1'b1;
                ctl.mode   = MODE_SUB;
            end
            OPC_ADDI, OPC_SUBI: begin
                ctl.alu_src   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.mode      = MODE_IMM;
            end
            OPC_ANDI, OPC_ORI: begin
                ctl.alu_src   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.zero_ext  = 1'b1;
                ctl.mode      = MODE_IMM;
            end
            default: begin
                ctl.bad_opc = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  alu_mode_e        mode,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output alu_op_e          op,
    output logic             shamt_sel,
    output logic             bad_funct
);

    always_comb begin
        op        = AOP_ADD;
        shamt_sel = 1'b0;
        bad_funct = 1'b0;
        unique case (mode)
            MODE_ADD: op = AOP_ADD;
            MODE_SUB: op = AOP_SUB;
            MODE_FUNCT: begin
                case (funct)
                    FN_ADD: op = AOP_ADD;
                    FN_SUB: op = AOP_SUB;
                    FN_AND: op = AOP_AND;
                    FN_OR:  op = AOP_OR;
                    FN_SLT: op = AOP_SLT;
                    FN_SLL: begin op = AOP_SLL; shamt_sel = 1'b1; end
                    FN_SRL: begin op = AOP_SRL; shamt_sel = 1'b1; end
                    FN_SRA: begin op = AOP_SRA; shamt_sel = 1'b1; end
                    default: bad_funct = 1'b1;
                endcase
            end
            MODE_IMM: begin
                case (opcode)
                    OPC_SUBI: op = AOP_SUB;
                    OPC_ANDI: op = AOP_AND;
                    OPC_ORI:  op = AOP_OR;
                    default:  op = AOP_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               reg_dst,
    output logic               branch,
    output logic               mem_read,
    output logic               mem_to_reg,
    output logic               mem_write,
    output logic               alu_src,
    output logic               reg_write,
    output logic [1:0]         alu_mode,
    output logic [3:0]         alu_op,
    output logic               shamt_sel,
    output logic               zero_ext,
    output logic               illegal
);

    localparam int OPC_LSB = INSTR_W - OPC_W;

    logic [OPC_W-1:0] opcode;
    logic [FN_W-1:0]  funct;
    main_ctl_t        main_ctl;
    alu_op_e          op_sel;
    logic             shift_sel;
    logic             bad_funct;

    assign opcode = instr[INSTR_W-1:OPC_LSB];
    assign funct  = instr[FN_W-1:0];

    ctl_main_dec u_main (
        .opcode (opcode),
        .ctl    (main_ctl)
    );

    ctl_alu_dec u_alu (
        .mode      (main_ctl.mode),
        .opcode    (opcode),
        .funct     (funct),
        .op        (op_sel),
        .shamt_sel (shift_sel),
        .bad_funct (bad_funct)
    );

    always_comb begin
        reg_dst    = main_ctl.reg_dst;
        branch     = main_ctl.branch;
        mem_read   = main_ctl.mem_read;
        mem_to_reg = main_ctl.mem_to_reg;
        mem_write  = main_ctl.mem_write;
        alu_src    = main_ctl.alu_src;
        reg_write  = main_ctl.reg_write & ~bad_funct;
        alu_mode   = main_ctl.mode;
        alu_op     = op_sel;
        shamt_sel  = shift_sel;
        zero_ext   = main_ctl.zero_ext;
        illegal    = main_ctl.bad_opc | bad_funct;
    end

    always_comb begin
        if (!$isunknown(instr)) begin
            p_mode_add_r1: assert (!(main_ctl.mode == MODE_ADD) || op_sel == AOP_ADD)
                else $error("p_mode_add_r1");
            p_branch_sub_r4: assert (!main_ctl.branch || op_sel == AOP_SUB)
                else $error("p_branch_sub_r4");
            p_shamt_rtype_r7: assert (!shift_sel || (main_ctl.mode == MODE_FUNCT && op_sel[3]))
                else $error("p_shamt_rtype_r7");
            p_zext_imm_r9: assert (!main_ctl.zero_ext || (main_ctl.alu_src && main_ctl.mode == MODE_IMM))
                else $error("p_zext_imm_r9");
            p_illegal_quiet_r10: assert (!(main_ctl.bad_opc | bad_funct) ||
                                         (!(main_ctl.reg_write & ~bad_funct) && !main_ctl.mem_read && !main_ctl.mem_write))
                else $error("p_illegal_quiet_r10");
            p_mem_excl_r3: assert (!(main_ctl.mem_read && main_ctl.mem_write))
                else $error("p_mem_excl_r3");
        end
    end

endmodule

// File: tb/ctl_decoder_tb_top.sv
module ctl_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        reg_dst, branch, mem_read, mem_to_reg, mem_write, alu_src, reg_write;
    logic [1:0]  alu_mode;
    logic [3:0]  alu_op;
    logic        shamt_sel, zero_ext, illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ctl_decoder dut_i (
        .instr      (instr),
        .reg_dst    (reg_dst),
        .branch     (branch),
        .mem_read   (mem_read),
        .mem_to_reg (mem_to_reg),
        .mem_write  (mem_write),
        .alu_src    (alu_src),
        .reg_write  (reg_write),
        .alu_mode   (alu_mode),
        .alu_op     (alu_op),
        .shamt_sel  (shamt_sel),
        .zero_ext   (zero_ext),
        .illegal    (illegal)
    );

    // packing: rd,br,mr,m2r,mw,src,rw,mode[2],op[4],sh,zx,ill
    function automatic logic [15:0] expect_ctl(input logic [5:0] op, input logic [5:0] fn);
        logic rd, br, mr, m2r, mw, src, rw, sh, zx, ill;
        logic [1:0] md;
        logic [3:0] ao;
        {rd, br, mr, m2r, mw, src, rw, sh, zx, ill} = '0;
        md = 2'b00;
        ao = 4'b0010;
        case (op)
            6'h00: begin
                rd = 1; rw = 1; md = 2'b10;
                case (fn)
                    6'h20: ao = 4'b0010;
                    6'h22: ao = 4'b0110;
                    6'h24: ao = 4'b0000;
                    6'h25: ao = 4'b0001;
                    6'h2A: ao = 4'b0111;
                    6'h00: begin ao = 4'b1000; sh = 1; end
                    6'h02: begin ao = 4'b1001; sh = 1; end
                    6'h03: begin ao = 4'b1010; sh = 1; end
                    default: begin rw = 0; ill = 1; end
                endcase
            end
            6'h23: begin mr = 1; m2r = 1; src = 1; rw = 1; end
            6'h2B: begin mw = 1; src = 1; end
            6'h04: begin br = 1; md = 2'b01; ao = 4'b0110; end
            6'h08: begin src = 1; rw = 1; md = 2'b11; ao = 4'b0010; end
            6'h09: begin src = 1; rw = 1; md = 2'b11; ao = 4'b0110; end
            6'h0C: begin src = 1; rw = 1; md = 2'b11; ao = 4'b0000; zx = 1; end
            6'h0D: begin src = 1; rw = 1; md = 2'b11; ao = 4'b0001; zx = 1; end
            default: ill = 1;
        endcase
        return {rd, br, mr, m2r, mw, src, rw, md, ao, sh, zx, ill};
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'h00: begin
                case (fn)
                    6'h00, 6'h02, 6'h03: return "R7";
                    6'h20, 6'h22, 6'h24, 6'h25, 6'h2A: return "R6";
                    default: return "R11";
                endcase
            end
            6'h23: return "R2";
            6'h2B: return "R3";
            6'h04: return "R4";
            6'h08, 6'h09: return "R8";
            6'h0C, 6'h0D: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check_word(input logic [31:0] w, input string tag);
        logic [15:0] exp_v, got;
        @(negedge clk);
        instr = w;
        #1;
        exp_v = expect_ctl(w[31:26], w[5:0]);
        got = {reg_dst, branch, mem_read, mem_to_reg, mem_write, alu_src, reg_write,
               alu_mode, alu_op, shamt_sel, zero_ext, illegal};
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s instr=%h actual=%b expected=%b", tag, w, got, exp_v);
        end
    endtask

    function automatic logic [31:0] word(input logic [5:0] op, input logic [5:0] fn, input logic [19:0] mid);
        return {op, mid, fn};
    endfunction

    initial begin
        logic [5:0] ops [8];
        logic [5:0] fns [8];
        int unused_seed;
        ops = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h08, 6'h09, 6'h0C, 6'h0D};
        fns = '{6'h00, 6'h02, 6'h03, 6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        unused_seed = $urandom(32'h5EED_0C7D);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-time word 0 is sll: R5 pattern with R7 shift select
        check_word(32'h0, "R5");
        // R1/R2: load, with junk in ignored fields (R12)
        check_word(word(6'h23, 6'h3F, 20'hABCDE), "R2");
        check_word(word(6'h2B, 6'h15, 20'h12345), "R3");
        check_word(word(6'h04, 6'h00, 20'hFFFFF), "R4");
        check_word(word(6'h00, 6'h20, 20'h0F0F0), "R6");
        check_word(word(6'h00, 6'h22, 20'h00001), "R6");
        check_word(word(6'h00, 6'h2A, 20'h55555), "R6");
        check_word(word(6'h00, 6'h03, 20'h007C0), "R7");
        check_word(word(6'h00, 6'h02, 20'h00000), "R7");
        check_word(word(6'h08, 6'h2A, 20'h8000F), "R8");
        check_word(word(6'h09, 6'h03, 20'h00000), "R8");
        check_word(word(6'h0C, 6'h00, 20'hFFFFF), "R9");
        check_word(word(6'h0D, 6'h24, 20'h11111), "R9");
        check_word(word(6'h3F, 6'h20, 20'h00000), "R10");
        check_word(word(6'h0A, 6'h00, 20'hAAAAA), "R10");
        check_word(word(6'h00, 6'h21, 20'h00000), "R11");
        check_word(word(6'h00, 6'h3F, 20'hFFFFF), "R11");
        // R1 and R12: random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(0, 3) != 0) w[31:26] = ops[$urandom_range(0, 7)];
            if ($urandom_range(0, 3) != 0) w[5:0] = fns[$urandom_range(0, 7)];
            check_word(w, req_of(w[31:26], w[5:0]));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule